// File: doc/BRIEF.md
# Shared-Mailbox Command Requester

This block drives the requester side of a 256-bit mailbox that is shared with a responder. The mailbox is reached through a simple dword register port. A command arrives on a valid/ready input and is one of two kinds. An establish command hands four queue base addresses and an interrupt vector to the responder. A destroy command carries only a header. For either kind the block first reads the header dword until the responder no longer owns the mailbox. It then writes the request and polls again until ownership comes back. Finally it checks the response header and reports one result code.

For an establish command, each byte address is turned into a page-frame number. Each frame number is split into a 48-bit low part and a 4-bit high nibble. The four low parts fill bytes 0 to 23. A 16-bit word of high nibbles and a 16-bit vector number come next, and the header dword comes last. The image is little-endian: byte k is bits [8(k%4)+7 : 8(k%4)] of dword k/4. The dwords are written in ascending index order, and ownership passes to the responder only when dword 7 is written.

Command input rules. `cmd_ready` is high only while the block is idle. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The command fields must stay stable while `cmd_valid` is high and `cmd_ready` is low. The result is a plain one-cycle pulse with no back-pressure. Register reads have a fixed latency: `reg_rdata` is sampled one cycle after `reg_rd_en`.

Top module: `mbox_requester`

## Requirements
- R1: `cmd_ready` is 1 only when idle and 0 from the cycle after acceptance until the result. Every accepted command produces exactly one `res_valid` pulse lasting one cycle, with `res_code` set to one of: 0 ok, 1 timeout, 2 protocol error, 3 operation failure, 4 bad argument.
- R2: Before writing, the block reads dword 7 and keeps polling while bit 31 (responder owns) is set. Consecutive reads are spaced POLL_GAP+2 cycles apart. No write happens before a read that shows bit 31 clear.
- R3: If MAX_POLLS reads in a row all show bit 31 set, the block reports code 1. When this happens in the first poll phase, no write is made.
- R4: An establish command writes all eight dwords, indices 0 to 7, in consecutive cycles. The data follows the packing above, where frame = address >> log2(PAGE_BYTES). Queue n (order: event, completion, receive, send) puts its frame bits [47:0] in bytes 6n to 6n+5, and its frame bits [51:48] in bits [4n+3:4n] of the nibble word (bytes 24–25). The vector number's low 16 bits go in bytes 26–27.
- R5: A destroy command writes only dword 7.
- R6: The request header has: bits [2:0] type (1 establish, 2 destroy), bits [5:3] version 0, bit 7 direction 0, bits [15:8] status 0, bit 24 the command's reset-function flag, bit 31 0, and all other bits 0.
- R7: For an establish command, a non page-aligned address or a vector index of 65536 or more gives code 4, with no register read or write.
- R8: After the request, the block polls dword 7 again, with the timing and limit of R2 and R3. A read with bit 31 clear, a matching type, version ≤ 0, direction bit 1 and status 0 gives code 0.
- R9: A response with a different type, a version above the request's, or direction 0 gives code 2.
- R10: A well-formed response whose status byte [15:8] is nonzero gives code 3.
- R11: When the reset-function flag is set, reading 0xFFFFFFFF in the response phase gives code 0 at once. Without the flag, that value counts as the responder still owning the mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_destroy | input | 1 | 1 destroy, 0 establish |
| cmd_reset_fn | input | 1 | Reset-function flag for the header |
| evq_addr | input | ADDR_W | Event queue byte address |
| cmpq_addr | input | ADDR_W | Completion queue byte address |
| rxq_addr | input | ADDR_W | Receive queue byte address |
| txq_addr | input | ADDR_W | Send queue byte address |
| vec_idx | input | 32 | Interrupt vector index |
| reg_rd_en | output | 1 | Read strobe for dword `reg_idx` |
| reg_wr_en | output | 1 | Write strobe for dword `reg_idx` |
| reg_idx | output | 3 | Mailbox dword index |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, one cycle after the strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 3 | Result code |

## Verification
The bench builds the block with POLL_GAP = 3 and MAX_POLLS = 5 and keeps the default 4 KiB page and 64-bit addresses. The short gap makes the read spacing exact and cheap to measure. The small limit makes both timeout paths, in the first phase and in the response phase, reachable in a few dozen cycles. With full 64-bit addresses, frame numbers use all 52 bits, so every nibble of the high-part word is exercised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW_BITS  = 32;
  localparam int IMG_BITS = 256;
  localparam int LO_W     = 48;
  localparam int HI_W     = 4;
  localparam int NIB_POS  = 4 * LO_W;
  localparam int VEC_POS  = NIB_POS + 16;
  localparam int HDR_POS  = VEC_POS + 16;
  localparam int OWN_BIT  = 31;
  localparam int DIR_BIT  = 7;
  localparam int RST_BIT  = 24;
  localparam logic [2:0] HDR_IDX  = 3'd7;
  localparam logic [2:0] TYPE_EST = 3'd1;
  localparam logic [2:0] TYPE_DES = 3'd2;
  localparam logic [2:0] REQ_VER  = 3'd0;

  typedef enum logic [2:0] {
    RES_OK = 3'd0, RES_TIMEOUT = 3'd1, RES_PROTO = 3'd2,
    RES_OPFAIL = 3'd3, RES_BADARG = 3'd4
  } res_code_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_EVAL, ST_GAP, ST_WR, ST_DONE
  } req_state_e;

  function automatic logic [31:0] mk_req_hdr(input logic [2:0] typ, input logic rst);
    logic [31:0] h;
    h = '0;
    h[2:0] = typ;
    h[5:3] = REQ_VER;
    h[RST_BIT] = rst;
    return h;
  endfunction
endpackage

// File: rtl/mbox_packer.sv
module mbox_packer import mbox_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int PG_SH  = 12
) (
  input  logic                   destroy,
  input  logic                   reset_fn,
  input  logic [3:0][ADDR_W-1:0] addrs,
  input  logic [31:0]            vec,
  output logic [IMG_BITS-1:0]    img,
  output logic                   args_ok
);
  logic [3:0][ADDR_W-1:0] frames;
  logic [3:0]             misal;

  for (genvar g = 0; g < 4; g++) begin : g_q
    assign frames[g] = addrs[g] >> PG_SH;
    assign misal[g]  = |addrs[g][PG_SH-1:0];
  end

  always_comb begin
    img = '0;
    for (int i = 0; i < 4; i++) begin
      img[LO_W*i +: LO_W] = frames[i][LO_W-1:0];
      img[NIB_POS + HI_W*i +: HI_W] = frames[i][LO_W +: HI_W];
    end
    img[VEC_POS +: 16] = vec[15:0];
    img[HDR_POS +: 32] = mk_req_hdr(destroy ? TYPE_DES : TYPE_EST, reset_fn);
  end

  assign args_ok = destroy || ((misal == 4'b0) && (vec[31:16] == 16'h0));
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int GAP_CYC   = 100000,
  parameter int MAX_TRIES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic att_clr,
  input  logic att_inc,
  input  logic gap_load,
  input  logic gap_run,
  output logic att_last,
  output logic gap_zero
);
  localparam int AW = $clog2(MAX_TRIES + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [AW-1:0] att_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (att_clr)      att_cnt <= '0;
      else if (att_inc) att_cnt <= att_cnt + 1'b1;
      if (gap_load)     gap_cnt <= GW'(GAP_CYC - 1);
      else if (gap_run && gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign att_last = (att_cnt == AW'(MAX_TRIES - 1));
  assign gap_zero = (gap_cnt == '0);

  AST_ATT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    att_cnt < AW'(MAX_TRIES)) else $error("attempt count out of range"); // R3
endmodule

// File: rtl/mbox_requester.sv
module mbox_requester import mbox_pkg::*; #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int POLL_GAP   = 100000,
  parameter int MAX_POLLS  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_destroy,
  input  logic              cmd_reset_fn,
  input  logic [ADDR_W-1:0] evq_addr,
  input  logic [ADDR_W-1:0] cmpq_addr,
  input  logic [ADDR_W-1:0] rxq_addr,
  input  logic [ADDR_W-1:0] txq_addr,
  input  logic [31:0]       vec_idx,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [2:0]        reg_idx,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata,
  output logic              res_valid,
  output logic [2:0]        res_code
);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  req_state_e            state;
  logic                  phase_post, op_des, rst_fn;
  logic [IMG_BITS-1:0]   image, img_next;
  logic [2:0]            wr_idx;
  res_code_e             code_q;
  logic                  args_ok;
  logic [3:0][ADDR_W-1:0] addrs;

  assign addrs = {txq_addr, rxq_addr, cmpq_addr, evq_addr};

  mbox_packer #(.ADDR_W(ADDR_W), .PG_SH(PG_SH)) u_pack (
    .destroy(cmd_destroy), .reset_fn(cmd_reset_fn), .addrs(addrs),
    .vec(vec_idx), .img(img_next), .args_ok(args_ok)
  );

  logic att_clr, att_inc, gap_load, gap_run, att_last, gap_zero;

  mbox_poll_timer #(.GAP_CYC(POLL_GAP), .MAX_TRIES(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .att_clr(att_clr), .att_inc(att_inc),
    .gap_load(gap_load), .gap_run(gap_run), .att_last(att_last), .gap_zero(gap_zero)
  );

  // evaluation of the dword-7 read
  logic       resp_ones, busy, hdr_bad, in_eval;
  logic [2:0] want_type;
  assign in_eval   = (state == ST_EVAL);
  assign resp_ones = rst_fn && phase_post && (reg_rdata == 32'hFFFF_FFFF);
  assign busy      = reg_rdata[OWN_BIT];
  assign want_type = op_des ? TYPE_DES : TYPE_EST;
  assign hdr_bad   = (reg_rdata[2:0] != want_type) || (reg_rdata[5:3] > REQ_VER)
                     || !reg_rdata[DIR_BIT];

  assign att_clr  = (state == ST_IDLE) || (state == ST_WR && wr_idx == HDR_IDX);
  assign att_inc  = in_eval && !resp_ones && busy && !att_last;
  assign gap_load = att_inc;
  assign gap_run  = (state == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase_post <= 1'b0;
      op_des     <= 1'b0;
      rst_fn     <= 1'b0;
      image      <= '0;
      wr_idx     <= '0;
      code_q     <= RES_OK;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_des     <= cmd_destroy;
          rst_fn     <= cmd_reset_fn;
          image      <= img_next;
          phase_post <= 1'b0;
          if (args_ok) state <= ST_RD;
          else begin
            code_q <= RES_BADARG;
            state  <= ST_DONE;
          end
        end
        ST_RD: state <= ST_EVAL;
        ST_EVAL: begin
          if (resp_ones) begin
            code_q <= RES_OK;
            state  <= ST_DONE;
          end else if (busy) begin
            if (att_last) begin
              code_q <= RES_TIMEOUT;
              state  <= ST_DONE;
            end else state <= ST_GAP;
          end else if (!phase_post) begin
            wr_idx <= op_des ? HDR_IDX : 3'd0;
            state  <= ST_WR;
          end else begin
            if (hdr_bad)                    code_q <= RES_PROTO;
            else if (reg_rdata[15:8] != 8'h0) code_q <= RES_OPFAIL;
            else                            code_q <= RES_OK;
            state <= ST_DONE;
          end
        end
        ST_GAP: if (gap_zero) state <= ST_RD;
        ST_WR: begin
          wr_idx <= wr_idx + 1'b1;
          if (wr_idx == HDR_IDX) begin
            phase_post <= 1'b1;
            state      <= ST_RD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign reg_rd_en = (state == ST_RD);
  assign reg_wr_en = (state == ST_WR);
  assign reg_idx   = (state == ST_WR) ? wr_idx : HDR_IDX;
  assign reg_wdata = image[32*wr_idx +: 32];
  assign res_valid = (state == ST_DONE);
  assign res_code  = code_q;

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid) else $error("result pulse too long"); // R1
  AST_WR_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_en) |-> !$past(reg_rdata[OWN_BIT])) else $error("write while owned"); // R2
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && $past(reg_wr_en)) |-> (reg_idx == $past(reg_idx) + 3'd1))
    else $error("write order broken"); // R4
  AST_HDR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_idx == HDR_IDX) |-> (reg_wdata[OWN_BIT] == 1'b0 &&
      reg_wdata[DIR_BIT] == 1'b0 && reg_wdata[15:8] == 8'h0)) else $error("bad request header"); // R6
  AST_BADARG_NOIO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_BADARG) |-> $past(cmd_ready))
    else $error("bad argument after bus activity"); // R7
endmodule

// File: tb/mbox_requester_tb.sv
module mbox_requester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;
  localparam int MAXP = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_destroy = 0, cmd_reset_fn = 0;
  logic [63:0] evq_addr = 0, cmpq_addr = 0, rxq_addr = 0, txq_addr = 0;
  logic [31:0] vec_idx = 0;
  logic cmd_ready, reg_rd_en, reg_wr_en, res_valid;
  logic [2:0] reg_idx, res_code;
  logic [31:0] reg_wdata, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_requester #(.ADDR_W(64), .PAGE_BYTES(4096), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_destroy(cmd_destroy), .cmd_reset_fn(cmd_reset_fn),
    .evq_addr(evq_addr), .cmpq_addr(cmpq_addr), .rxq_addr(rxq_addr), .txq_addr(txq_addr),
    .vec_idx(vec_idx), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid), .res_code(res_code)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  // responder configuration (set by tasks only)
  int pre_busy = 0, post_busy = 0;
  logic [31:0] resp_word = 0;
  // responder log (written by responder only)
  int npre, npost, nwr;
  logic seen7;
  int rdcyc [16];
  int wcyc [16];
  logic [2:0] widx [16];
  logic [31:0] wdat [16];
  logic [2:0] got_code;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      npre <= 0; npost <= 0; nwr <= 0; seen7 <= 0;
    end else begin
      if (reg_rd_en) begin
        if (!seen7) begin
          if (npre < 16) rdcyc[npre] <= cyc;
          reg_rdata <= (npre < pre_busy) ? 32'h8000_0000 : 32'h0;
          npre <= npre + 1;
        end else begin
          reg_rdata <= (npost < post_busy) ? 32'h8000_0000 : resp_word;
          npost <= npost + 1;
        end
      end
      if (reg_wr_en) begin
        if (nwr < 16) begin
          widx[nwr] <= reg_idx; wdat[nwr] <= reg_wdata; wcyc[nwr] <= cyc;
        end
        nwr <= nwr + 1;
        if (reg_idx == 3'd7) seen7 <= 1'b1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_resp(input logic [2:0] t, input logic [2:0] v,
                                          input logic d, input logic [7:0] s);
    return {16'h0, s, d, 1'b0, v, t};
  endfunction

  task automatic run_cmd(input logic des, input logic rf, input logic [63:0] a0, input logic [63:0] a1,
                         input logic [63:0] a2, input logic [63:0] a3, input logic [31:0] v,
                         input int pb, input int qb, input logic [31:0] rw);
    bit seen = 0;
    pre_busy = pb; post_busy = qb; resp_word = rw;
    @(negedge clk);
    cmd_destroy = des; cmd_reset_fn = rf; evq_addr = a0; cmpq_addr = a1;
    rxq_addr = a2; txq_addr = a3; vec_idx = v; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (!res_valid) chk(cmd_ready == 0, "R1 ready low while busy", cmd_ready, 0);
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (res_valid) begin
        seen = 1; got_code = res_code;
      end else @(negedge clk);
    end
    if (!seen) begin
      got_code = 3'd7;
      chk(0, "R1 result pulse", 0, 1);
    end
    @(negedge clk);
    chk(res_valid == 0 && cmd_ready == 1, "R1 pulse one cycle then idle", {res_valid, cmd_ready}, 2'b01);
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1 && res_valid == 0 && reg_wr_en == 0 && reg_rd_en == 0,
        "R1 reset state", {cmd_ready, res_valid, reg_wr_en, reg_rd_en}, 4'b1000);
  endtask

  task automatic t_establish;
    logic [63:0] a [4];
    logic [7:0]  by [32];
    logic [15:0] nib;
    logic [31:0] d;
    a[0] = 64'hA123_4567_89AB_C000; a[1] = 64'h0000_0001_2345_6000;
    a[2] = 64'h5FFF_FFFF_FFFF_F000; a[3] = 64'h0000_0000_0000_1000;
    nib = 0;
    for (int n = 0; n < 4; n++) begin
      logic [63:0] fr;
      fr = a[n] >> 12;
      for (int b = 0; b < 6; b++) by[6*n+b] = fr[8*b +: 8];
      nib[4*n +: 4] = fr[51:48];
    end
    by[24] = nib[7:0]; by[25] = nib[15:8];
    by[26] = 8'hEF; by[27] = 8'hBE;
    by[28] = 8'h01; by[29] = 8'h00; by[30] = 8'h00; by[31] = 8'h00;
    run_cmd(0, 0, a[0], a[1], a[2], a[3], 32'h0000_BEEF, 2, 1, mk_resp(1, 0, 1, 0));
    chk(got_code == 0, "R8 establish ok", got_code, 0);
    chk(npre == 3, "R2 pre-phase reads", npre, 3);
    chk(rdcyc[1] - rdcyc[0] == GAP + 2, "R2 read spacing", rdcyc[1] - rdcyc[0], GAP + 2);
    chk(nwr == 8, "R4 eight writes", nwr, 8);
    chk(wcyc[7] - wcyc[0] == 7, "R4 consecutive writes", wcyc[7] - wcyc[0], 7);
    for (int k = 0; k < 8; k++) begin
      d = {by[4*k+3], by[4*k+2], by[4*k+1], by[4*k]};
      chk(widx[k] == 3'(k) && wdat[k] == d, "R4 packed dword", {widx[k], wdat[k]}, {3'(k), d});
    end
    chk(wdat[7] == 32'h0000_0001, "R6 establish header", wdat[7], 32'h1);
    chk(npost == 2, "R8 response polled past busy", npost, 2);
  endtask

  task automatic t_destroy;
    run_cmd(1, 1, 64'h123, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, mk_resp(2, 0, 1, 0));
    chk(got_code == 0, "R8 destroy ok", got_code, 0);
    chk(nwr == 1 && widx[0] == 3'd7, "R5 single header write", {nwr[7:0], 5'b0, widx[0]}, {8'd1, 8'd7});
    chk(wdat[0] == 32'h0100_0002, "R6 destroy header with reset flag", wdat[0], 32'h0100_0002);
  endtask

  task automatic t_pre_timeout;
    run_cmd(1, 0, 0, 0, 0, 0, 0, 100, 0, 0);
    chk(got_code == 1, "R3 pre-phase timeout", got_code, 1);
    chk(npre == MAXP, "R3 read count", npre, MAXP);
    chk(nwr == 0, "R3 no write", nwr, 0);
  endtask

  task automatic t_badarg;
    run_cmd(0, 0, 64'h1000, 64'h2008, 64'h3000, 64'h4000, 32'h5, 0, 0, 0);
    chk(got_code == 4 && npre == 0 && nwr == 0, "R7 misaligned", {got_code, npre[7:0], nwr[7:0]}, {3'd4, 16'h0});
    run_cmd(0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h0001_0000, 0, 0, 0);
    chk(got_code == 4 && npre == 0 && nwr == 0, "R7 vector too wide", {got_code, npre[7:0], nwr[7:0]}, {3'd4, 16'h0});
  endtask

  task automatic t_proto;
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, mk_resp(1, 0, 1, 0));
    chk(got_code == 2, "R9 type mismatch", got_code, 2);
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, mk_resp(2, 1, 1, 0));
    chk(got_code == 2, "R9 newer version", got_code, 2);
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, mk_resp(2, 0, 0, 0));
    chk(got_code == 2, "R9 request direction", got_code, 2);
  endtask

  task automatic t_opfail;
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 1, mk_resp(2, 0, 1, 8'h05));
    chk(got_code == 3, "R10 nonzero status", got_code, 3);
  endtask

  task automatic t_ones;
    run_cmd(0, 1, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h7, 0, 0, 32'hFFFF_FFFF);
    chk(got_code == 0 && npost == 1, "R11 all-ones with reset flag", {got_code, npost[7:0]}, {3'd0, 8'd1});
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    chk(got_code == 1 && npost == MAXP, "R11 all-ones without flag times out", {got_code, npost[7:0]}, {3'd1, 8'(MAXP)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reg_rdata = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_establish;
    t_destroy;
    t_pre_timeout;
    t_badarg;
    t_proto;
    t_opfail;
    t_ones;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule